// File: doc/BRIEF.md
# Most-Deficit Head-Cache Refill Scheduler

This block decides which per-queue head cache gets refilled from a slow bulk memory. The bulk memory holds the bodies of many FIFOs, and a small fast cache in front of it keeps the next units of each FIFO ready for readout. In any cycle at most one read request arrives, naming a queue, and it takes one unit from that queue's cache. Once every `BLK` cycles the scheduler names one queue and issues a refill command. The command moves `BLK` units from bulk memory into that queue's cache. The block only counts units: it keeps a signed deficit per queue, defined as units consumed minus units delivered. Every cache starts full at reset with `CACHE_PER_Q` units.

On each refill slot the scheduler picks the eligible queue whose deficit is largest. A queue is eligible only if it has a positive deficit and bulk memory reports data for it. A request to a queue whose cache is empty is flagged as an underflow. When `CACHE_PER_Q` is at least `BLK·(2 + ln NUM_Q)`, this policy keeps every request served without adding any latency.

Top module: `mdq_refill_arbiter`

## Requirements
- R1: While `rst_ni` is low, `repl_valid_o` and `underflow_o` are low. After release, every deficit is zero and the slot counter is at zero.
- R2: Cycles are counted from 0 after reset release. A refill command (`repl_valid_o` high) can only appear in cycles BLK, 2·BLK, 3·BLK and so on, and it lasts one cycle.
- R3: A request to queue q with a non-empty cache raises q's deficit by one. A refill to q lowers q's deficit by `BLK`. When a request and a refill land in the same cycle, both changes apply.
- R4: On a refill, `repl_qid_o` names the eligible queue with the largest deficit.
- R5: When several eligible queues share the largest deficit, the lowest queue index is chosen.
- R6: A queue whose bit in `avail_i` was low in the decision cycle is never chosen.
- R7: A queue with a deficit of zero or less is not eligible. If no queue is eligible in the decision cycle, no refill is issued in that slot.
- R8: The cache of queue q is empty when its deficit equals `CACHE_PER_Q`. A valid request to an empty queue drives `underflow_o` high for one cycle in the next cycle, and it leaves that queue's deficit unchanged.
- R9: A request is ignored if `req_valid_i` is low or if `req_qid_i` ≥ `NUM_Q`. An ignored request changes no deficit and raises no underflow.
- R10: The decision taken in cycle k·BLK−1 uses the deficits held at the start of that cycle. A request in that same cycle does not affect the choice.
- R11: With `CACHE_PER_Q` = 22 (≥ 6·(2+ln 5)), all queues available and random single requests every cycle, `underflow_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present this cycle |
| req_qid_i | input | $clog2(NUM_Q) | Queue targeted by the request |
| avail_i | input | NUM_Q | Per-queue flag: bulk memory can supply a block |
| repl_valid_o | output | 1 | Refill command issued |
| repl_qid_o | output | $clog2(NUM_Q) | Queue being refilled |
| underflow_o | output | 1 | Previous-cycle request found its cache empty |

## Verification
The assertions rely on two input conditions. First, `avail_i` is sampled at the decision edge and is not required to be stable at any other time. Second, `req_qid_i` may hold any value while `req_valid_i` is low, or may be out of range, and the checks on refill choice do not depend on it. The stimulus never drives inputs near a clock edge. It changes `avail_i` freely between table rows, and it deliberately places junk queue IDs on idle and out-of-range requests, so these conditions are met while the ignore paths are still exercised. The random phase keeps every queue available, which matches the premise of the no-underflow bound.

// File: rtl/mdq_pkg.sv
package mdq_pkg;
  localparam int unsigned DEF_NUM_Q       = 5;
  localparam int unsigned DEF_BLK         = 6;
  // ceil(BLK*(2+ln NUM_Q)) for the defaults
  localparam int unsigned DEF_CACHE_PER_Q = 22;

  function automatic int unsigned idx_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/mdq_slot_timer.sv
module mdq_slot_timer
  import mdq_pkg::*;
#(
  parameter int unsigned BLK = DEF_BLK
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic decide_o
);
  localparam int unsigned SW = idx_w(BLK);
  localparam logic [SW-1:0] LAST = SW'(BLK - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + SW'(1);
  end

  assign decide_o = (slot_q == LAST);
endmodule

// File: rtl/mdq_deficit_bank.sv
module mdq_deficit_bank
  import mdq_pkg::*;
#(
  parameter int unsigned NUM_Q       = DEF_NUM_Q,
  parameter int unsigned BLK         = DEF_BLK,
  parameter int unsigned CACHE_PER_Q = DEF_CACHE_PER_Q,
  parameter int unsigned QW          = idx_w(NUM_Q),
  parameter int unsigned DW          = idx_w(CACHE_PER_Q + BLK + 1) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [QW-1:0]        req_qid_i,
  input  logic                 fill_valid_i,
  input  logic [QW-1:0]        fill_qid_i,
  output logic signed [DW-1:0] def_o [NUM_Q],
  output logic [NUM_Q-1:0]     empty_o
);
  localparam logic signed [DW-1:0] STEP_ONE = DW'(1);
  localparam logic signed [DW-1:0] STEP_BLK = DW'(BLK);
  localparam logic signed [DW-1:0] FULL_DEF = DW'(CACHE_PER_Q);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic signed [DW-1:0] def_q;
    logic signed [DW-1:0] def_d;
    logic                 take;
    logic                 give;

    assign empty_o[g] = (def_q == FULL_DEF);
    assign take       = req_valid_i && (req_qid_i == QW'(g)) && !empty_o[g];
    assign give       = fill_valid_i && (fill_qid_i == QW'(g));

    always_comb begin
      def_d = def_q;
      if (take) def_d = def_d + STEP_ONE;
      if (give) def_d = def_d - STEP_BLK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) def_q <= '0;
      else         def_q <= def_d;
    end

    assign def_o[g] = def_q;
  end
endmodule

// File: rtl/mdq_max_select.sv
module mdq_max_select
  import mdq_pkg::*;
#(
  parameter int unsigned NUM_Q = DEF_NUM_Q,
  parameter int unsigned QW    = idx_w(NUM_Q),
  parameter int unsigned DW    = 8
) (
  input  logic signed [DW-1:0] def_i [NUM_Q],
  input  logic [NUM_Q-1:0]     elig_i,
  output logic                 found_o,
  output logic [QW-1:0]        idx_o
);
  logic signed [DW-1:0] best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (elig_i[q] && (!found_o || def_i[q] > best)) begin
        found_o = 1'b1;
        idx_o   = QW'(q);
        best    = def_i[q];
      end
    end
  end
endmodule

// File: rtl/mdq_refill_arbiter.sv
module mdq_refill_arbiter
  import mdq_pkg::*;
#(
  parameter int unsigned NUM_Q       = DEF_NUM_Q,
  parameter int unsigned BLK         = DEF_BLK,
  parameter int unsigned CACHE_PER_Q = DEF_CACHE_PER_Q,
  parameter int unsigned QW          = idx_w(NUM_Q)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [QW-1:0]    req_qid_i,
  input  logic [NUM_Q-1:0] avail_i,
  output logic             repl_valid_o,
  output logic [QW-1:0]    repl_qid_o,
  output logic             underflow_o
);
  localparam int unsigned DW = idx_w(CACHE_PER_Q + BLK + 1) + 1;
  localparam logic signed [DW-1:0] ZERO_S = '0;

  logic                 decide;
  logic signed [DW-1:0] def [NUM_Q];
  logic [NUM_Q-1:0]     empty;
  logic [NUM_Q-1:0]     elig;
  logic                 found;
  logic [QW-1:0]        pick;
  logic                 fire;
  logic                 uf_d;
  logic                 repl_valid_q;
  logic [QW-1:0]        repl_qid_q;
  logic                 underflow_q;

  mdq_slot_timer #(.BLK(BLK)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .decide_o (decide)
  );

  mdq_deficit_bank #(
    .NUM_Q(NUM_Q), .BLK(BLK), .CACHE_PER_Q(CACHE_PER_Q), .QW(QW), .DW(DW)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_qid_i    (req_qid_i),
    .fill_valid_i (fire),
    .fill_qid_i   (pick),
    .def_o        (def),
    .empty_o      (empty)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_elig
    assign elig[g] = avail_i[g] && (def[g] > ZERO_S);
  end

  mdq_max_select #(.NUM_Q(NUM_Q), .QW(QW), .DW(DW)) u_sel (
    .def_i   (def),
    .elig_i  (elig),
    .found_o (found),
    .idx_o   (pick)
  );

  assign fire = decide && found;

  always_comb begin
    uf_d = 1'b0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (req_valid_i && req_qid_i == QW'(q) && empty[q]) uf_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      repl_valid_q <= 1'b0;
      repl_qid_q   <= '0;
      underflow_q  <= 1'b0;
    end else begin
      repl_valid_q <= fire;
      if (fire) repl_qid_q <= pick;
      underflow_q  <= uf_d;
    end
  end

  assign repl_valid_o = repl_valid_q;
  assign repl_qid_o   = repl_qid_q;
  assign underflow_o  = underflow_q;
endmodule

// File: rtl/mdq_refill_arbiter_chk.sv
module mdq_refill_arbiter_chk
  import mdq_pkg::*;
#(
  parameter int unsigned NUM_Q       = DEF_NUM_Q,
  parameter int unsigned BLK         = DEF_BLK,
  parameter int unsigned CACHE_PER_Q = DEF_CACHE_PER_Q,
  parameter int unsigned QW          = idx_w(NUM_Q)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [QW-1:0]    req_qid_i,
  input logic [NUM_Q-1:0] avail_i,
  input logic             repl_valid_o,
  input logic [QW-1:0]    repl_qid_o,
  input logic             underflow_o
);
  localparam int unsigned SW = idx_w(BLK);

  logic [SW-1:0]    ph_q;
  logic [NUM_Q-1:0] avail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      avail_q <= '0;
    end else begin
      ph_q    <= (ph_q == SW'(BLK - 1)) ? '0 : ph_q + SW'(1);
      avail_q <= avail_i;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!repl_valid_o && !underflow_o));

  // R2
  refill_cadence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_valid_o |-> (ph_q == '0));

  // R2
  refill_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_valid_o |=> !repl_valid_o);

  // R4
  refill_qid_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_valid_o |-> ({1'b0, repl_qid_o} < (QW+1)'(NUM_Q)));

  // R6
  refill_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_valid_o |-> avail_q[repl_qid_o]);

  // R8
  underflow_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> $past(req_valid_i));

  // R9
  underflow_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> ({1'b0, $past(req_qid_i)} < (QW+1)'(NUM_Q)));
endmodule

bind mdq_refill_arbiter mdq_refill_arbiter_chk #(
  .NUM_Q(NUM_Q), .BLK(BLK), .CACHE_PER_Q(CACHE_PER_Q), .QW(QW)
) u_chk (.*);

// File: tb/tb_mdq_refill_arbiter.sv
module tb_mdq_refill_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NQ  = 5;
  localparam int BLK = 6;
  localparam int CAP = 22;
  localparam int QW  = 3;
  localparam int NT  = 16;

  // {valid, qid, avail, repeat}
  localparam logic [16:0] TBL [NT] = '{
    {1'b1, 3'd0, 5'b11111, 8'd3},
    {1'b1, 3'd2, 5'b11111, 8'd5},
    {1'b0, 3'd7, 5'b11111, 8'd4},
    {1'b1, 3'd4, 5'b11111, 8'd6},
    {1'b1, 3'd7, 5'b11111, 8'd3},
    {1'b1, 3'd1, 5'b11011, 8'd8},
    {1'b1, 3'd3, 5'b10101, 8'd6},
    {1'b0, 3'd0, 5'b00000, 8'd6},
    {1'b1, 3'd2, 5'b01111, 8'd12},
    {1'b1, 3'd0, 5'b11110, 8'd7},
    {1'b1, 3'd4, 5'b11111, 8'd10},
    {1'b1, 3'd1, 5'b11111, 8'd30},
    {1'b0, 3'd0, 5'b11111, 8'd12},
    {1'b1, 3'd3, 5'b00000, 8'd25},
    {1'b1, 3'd3, 5'b11111, 8'd12},
    {1'b0, 3'd0, 5'b11111, 8'd12}
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           req_valid_i = 1'b0;
  logic [QW-1:0]  req_qid_i = '0;
  logic [NQ-1:0]  avail_i = '0;
  logic           repl_valid_o;
  logic [QW-1:0]  repl_qid_o;
  logic           underflow_o;

  int checks = 0;
  int fails  = 0;
  int mdef [NQ];
  int mslot;
  int uf_seen;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mdq_refill_arbiter #(.NUM_Q(NQ), .BLK(BLK), .CACHE_PER_Q(CAP)) dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    req_qid_i = '0;
    avail_i = '0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(!repl_valid_o, "R1", "repl_valid in reset", int'(repl_valid_o), 0);
    chk(!underflow_o, "R1", "underflow in reset", int'(underflow_o), 0);
    rst_ni = 1'b1;
    foreach (mdef[i]) mdef[i] = 0;
    mslot = 0;
  endtask

  // called just after a posedge; drives one cycle and checks its outcome
  task automatic step(input bit v, input int q, input logic [NQ-1:0] av,
                      input string tag);
    bit exp_uf;
    int best;
    req_valid_i = v;
    req_qid_i   = QW'(q);
    avail_i     = av;
    exp_uf = v && q < NQ && mdef[q] >= CAP;
    best = -1;
    if (mslot == BLK - 1) begin
      for (int i = 0; i < NQ; i++)
        if (av[i] && mdef[i] > 0 && (best < 0 || mdef[i] > mdef[best])) best = i;
    end
    if (v && q < NQ && mdef[q] < CAP) mdef[q]++;
    if (best >= 0) mdef[best] -= BLK;
    mslot = (mslot + 1) % BLK;
    @(posedge clk_i);
    #1;
    chk(repl_valid_o == (best >= 0), tag, "repl_valid",
        int'(repl_valid_o), int'(best >= 0));
    if (best >= 0)
      chk(int'(repl_qid_o) == best, tag, "repl_qid", int'(repl_qid_o), best);
    chk(underflow_o == exp_uf, tag, "underflow", int'(underflow_o), int'(exp_uf));
    if (underflow_o) uf_seen++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;

    // table walk: R3 R4 R6 R7 R8 R9 mixed
    do_reset();
    for (int e = 0; e < NT; e++) begin
      for (int r = 0; r < int'(TBL[e][7:0]); r++)
        step(TBL[e][16], int'(TBL[e][15:13]), TBL[e][12:8], "R3/R4");
    end

    // R7: nothing consumed, first slot issues nothing
    do_reset();
    for (int c = 0; c < 2 * BLK; c++) step(1'b0, 0, 5'b11111, "R7");

    // R5: equal deficits on q3 and q1 -> q1
    do_reset();
    step(1'b1, 3, 5'b11111, "R5");
    step(1'b1, 1, 5'b11111, "R5");
    for (int c = 0; c < BLK; c++) step(1'b0, 0, 5'b11111, "R5");

    // R6: q2 largest but unavailable -> q0
    do_reset();
    step(1'b1, 2, 5'b11011, "R6");
    step(1'b1, 2, 5'b11011, "R6");
    step(1'b1, 2, 5'b11011, "R6");
    step(1'b1, 0, 5'b11011, "R6");
    for (int c = 0; c < BLK; c++) step(1'b0, 0, 5'b11011, "R6");

    // R10: request in decision cycle does not change the pick
    do_reset();
    step(1'b1, 1, 5'b11111, "R10");
    step(1'b1, 1, 5'b11111, "R10");
    step(1'b1, 4, 5'b11111, "R10");
    step(1'b1, 4, 5'b11111, "R10");
    step(1'b0, 4, 5'b11111, "R10");
    step(1'b1, 4, 5'b11111, "R10");
    for (int c = 0; c < BLK; c++) step(1'b0, 0, 5'b11111, "R10");

    // R4: distinct deficits -> largest
    do_reset();
    step(1'b1, 0, 5'b11111, "R4");
    step(1'b1, 2, 5'b11111, "R4");
    step(1'b1, 2, 5'b11111, "R4");
    step(1'b1, 2, 5'b11111, "R4");
    step(1'b1, 4, 5'b11111, "R4");
    step(1'b0, 4, 5'b11111, "R4");
    for (int c = 0; c < 2 * BLK; c++) step(1'b0, 0, 5'b11111, "R4");

    // R8 and R9: drain q0 with no refills, then hit it and junk IDs
    do_reset();
    for (int c = 0; c < CAP + 3; c++) step(1'b1, 0, 5'b00000, "R8");
    step(1'b1, 6, 5'b00000, "R9");
    step(1'b0, 0, 5'b00000, "R9");
    step(1'b1, 0, 5'b00001, "R8");

    // R11: random single requests, all queues available
    do_reset();
    uf_seen = 0;
    lfsr = 16'hACE1;
    for (int c = 0; c < 6000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0] != 3'd0, int'(lfsr[15:8]) % NQ, 5'b11111, "R11");
    end
    chk(uf_seen == 0, "R11", "underflow count", uf_seen, 0);

    // R1: reset in the middle of traffic clears state
    do_reset();
    chk(!repl_valid_o && !underflow_o, "R1", "outputs after release",
        int'(repl_valid_o) + int'(underflow_o), 0);
    for (int c = 0; c < BLK; c++) step(1'b0, 0, 5'b11111, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule